// File: doc/BRIEF.md
# Packet-Committing Synchronous Slave FIFO

This block is the device side of a clocked write port. An external master drives an address field that picks one of several endpoint FIFOs, a data word, an active-low chip select and an active-low write strobe. On every rising edge where both strobes are low, the word is stored in the chosen FIFO. Holding both low for several cycles stores one word per edge.

Stored words are grouped into packets. A packet is closed in one of two ways. Auto-commit closes it as soon as its word count reaches a programmed length. An active-low packet-end strobe closes a short packet by hand, and a word written on the same edge as the strobe is part of that packet. Committed packet lengths go into a per-FIFO length queue. A reader, through a single selected lane, pops whole-packet lengths and committed words. Words that are not yet committed cannot be read.

Each lane has a two-state packet machine. `PKT_IDLE` means no words are open. `PKT_OPEN` means at least one uncommitted word is held. The transitions are:

- `PKT_IDLE -> PKT_OPEN` on an accepted write that does not commit.
- `PKT_OPEN -> PKT_IDLE` on any commit, whether auto or manual.
- `PKT_IDLE -> PKT_IDLE` on a commit in idle. This is either a one-word packet written with the strobe, or a zero-length packet that sets the sticky error.
- `PKT_OPEN -> PKT_OPEN` on writes that do not commit.

Top module: `pkt_slave_fifo`

## Requirements
- R1: A word is stored on a rising edge only when `cs_n` and `wr_n` are both 0 at that edge. With either one at 1, no FIFO changes.
- R2: With both strobes held low, one word is stored on every edge. Words are read back in write order. `rd_data` shows the oldest committed word of lane `rd_sel`.
- R3: `fifo_empty` and `fifo_full` are driven from registers. They change only after the edge that caused the change.
- R4: When `pkt_end_n` is 0 on the same edge as a write to the same lane, the committed length includes that word.
- R5: `pkt_end_n` at 0 on an edge with no write commits every open word of lane `wr_sel` as one packet. `cs_n` and `wr_n` play no part in this.
- R6: With `auto_en` at 1 and `auto_len` non-zero, a packet commits on the write edge where its open count reaches `auto_len`.
- R7: A packet-end on a lane with no open words queues a zero-length packet and sets that lane's bit of `zero_pkt_err`. The bit stays set until reset.
- R8: A lane is full when it holds 16 words or 16 queued lengths. Writes to a full lane are dropped.
- R9: `rd_valid` is 1 only while lane `rd_sel` holds committed, unread words. Open words are not visible to the reader.
- R10: `pkt_pop` removes the head length of lane `rd_sel`, and `word_pop` removes its oldest committed word. Lengths come out in commit order. `pkt_avail` and `pkt_len` describe the head length.
- R11: Writes and packet-ends act only on the lane selected by `wr_sel`. Other lanes keep their state.
- R12: After reset, every lane is empty and not full, no error bit is set, and no packet is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| wr_sel | input | 2 | Target lane for writes and packet-end |
| wr_data | input | 16 | Write data word |
| pkt_end_n | input | 1 | Active-low packet-end strobe |
| auto_en | input | 1 | Enables auto-commit |
| auto_len | input | 5 | Auto-commit length, 0 disables |
| fifo_full | output | 4 | Per-lane full flag |
| fifo_empty | output | 4 | Per-lane empty flag, counting open and committed words |
| rd_sel | input | 2 | Lane seen by the read side |
| word_pop | input | 1 | Removes one committed word from lane `rd_sel` |
| rd_data | output | 16 | Oldest committed word of lane `rd_sel` |
| rd_valid | output | 1 | `rd_data` holds a committed word |
| pkt_pop | input | 1 | Removes the head packet length of lane `rd_sel` |
| pkt_avail | output | 1 | Lane `rd_sel` has a queued length |
| pkt_len | output | 5 | Head packet length of lane `rd_sel` |
| zero_pkt_err | output | 4 | Per-lane sticky zero-length packet flag |

## Verification
The bench targets these corner cases:

- **Packet-end on the write edge.** A design that samples the strobe before counting the word would commit one word short.
- **Packet-end one cycle after an auto-commit.** A design that drops this case would lose the zero-length packet or never set the error.
- **Writes into a full lane.** A design that accepts them would overwrite the oldest word and corrupt the committed count.
- **Read-side visibility of open words.** A design that exposes them would assert `rd_valid` too early.

Alongside these, a long random phase with rare packet-ends and mixed pops compares every flag and read output against a queue model on each cycle.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

    // Per-lane packet assembly state
    typedef enum logic {
        PKT_IDLE = 1'b0,   // no uncommitted words held
        PKT_OPEN = 1'b1    // at least one uncommitted word held
    } pkt_state_e;

endpackage

// File: rtl/pfs_lane_store.sv
module pfs_lane_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [DW-1:0]                 push_data,
    input  logic                          pop,
    output logic [DW-1:0]                 head_data,
    output logic [$clog2(DEPTH+1)-1:0]    fill
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
            fill <= '0;
        end else begin
            if (push) wp_q <= bump(wp_q);
            if (pop)  rp_q <= bump(rp_q);
            fill <= fill + CW'(push) - CW'(pop);
        end
    end

    assign head_data = mem[rp_q];

endmodule

// File: rtl/pfs_lane_ctrl.sv
module pfs_lane_ctrl
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int LQ_DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_hit,
    input  logic                          end_hit,
    input  logic                          word_req,
    input  logic                          pkt_req,
    input  logic                          auto_en,
    input  logic [$clog2(DEPTH+1)-1:0]    auto_len,
    input  logic [$clog2(DEPTH+1)-1:0]    store_fill,
    output logic                          wr_ok,
    output logic                          word_ok,
    output logic                          full,
    output logic                          words_ready,
    output logic                          pkt_avail,
    output logic [$clog2(DEPTH+1)-1:0]    pkt_len,
    output logic                          err
);
    localparam int CW  = $clog2(DEPTH+1);
    localparam int QAW = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1;
    localparam int QCW = $clog2(LQ_DEPTH+1);

    pkt_state_e       state_q, state_d;
    logic [CW-1:0]    open_q, ready_q, next_open;
    logic [CW-1:0]    len_mem [LQ_DEPTH];
    logic [QAW-1:0]   lq_wp, lq_rp;
    logic [QCW-1:0]   lq_cnt;
    logic             auto_fire, man_fire, commit, pkt_ok, zero_len;

    function automatic logic [QAW-1:0] qbump(input logic [QAW-1:0] p);
        return (p == QAW'(LQ_DEPTH-1)) ? '0 : p + QAW'(1);
    endfunction

    assign full      = (store_fill == CW'(DEPTH)) || (lq_cnt == QCW'(LQ_DEPTH));
    assign wr_ok     = wr_hit && !full;
    assign word_ok   = word_req && (ready_q != '0);
    assign pkt_ok    = pkt_req && (lq_cnt != '0);
    assign next_open = open_q + CW'(wr_ok);
    assign auto_fire = auto_en && wr_ok && (auto_len != '0) && (next_open >= auto_len);
    assign man_fire  = end_hit && (lq_cnt != QCW'(LQ_DEPTH));
    assign commit    = auto_fire || man_fire;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PKT_IDLE: if (wr_ok && !commit) state_d = PKT_OPEN;
            PKT_OPEN: if (commit)           state_d = PKT_IDLE;
        endcase
    end

    // Output decode: a manual close from idle with no word is empty
    always_comb begin
        zero_len = 1'b0;
        unique case (state_q)
            PKT_IDLE: zero_len = man_fire && !wr_ok;
            PKT_OPEN: zero_len = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PKT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q  <= '0;
            ready_q <= '0;
            err     <= 1'b0;
            lq_wp   <= '0;
            lq_rp   <= '0;
            lq_cnt  <= '0;
        end else begin
            open_q  <= commit ? '0 : next_open;
            ready_q <= ready_q + (commit ? next_open : '0) - CW'(word_ok);
            if (zero_len) err <= 1'b1;
            if (commit)   lq_wp <= qbump(lq_wp);
            if (pkt_ok)   lq_rp <= qbump(lq_rp);
            lq_cnt <= lq_cnt + QCW'(commit) - QCW'(pkt_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (commit) len_mem[lq_wp] <= next_open;
    end

    assign words_ready = (ready_q != '0);
    assign pkt_avail   = (lq_cnt != '0);
    assign pkt_len     = len_mem[lq_rp];

endmodule

// File: rtl/pkt_slave_fifo.sv
module pkt_slave_fifo #(
    parameter int NUM_FIFO = 4,
    parameter int DEPTH    = 16,
    parameter int DW       = 16,
    parameter int LQ_DEPTH = 16,
    localparam int SW      = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1,
    localparam int CW      = $clog2(DEPTH+1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 wr_n,
    input  logic [SW-1:0]        wr_sel,
    input  logic [DW-1:0]        wr_data,
    input  logic                 pkt_end_n,
    input  logic                 auto_en,
    input  logic [CW-1:0]        auto_len,
    output logic [NUM_FIFO-1:0]  fifo_full,
    output logic [NUM_FIFO-1:0]  fifo_empty,
    input  logic [SW-1:0]        rd_sel,
    input  logic                 word_pop,
    output logic [DW-1:0]        rd_data,
    output logic                 rd_valid,
    input  logic                 pkt_pop,
    output logic                 pkt_avail,
    output logic [CW-1:0]        pkt_len,
    output logic [NUM_FIFO-1:0]  zero_pkt_err
);
    logic [DW-1:0]       lane_head  [NUM_FIFO];
    logic [CW-1:0]       lane_len   [NUM_FIFO];
    logic [NUM_FIFO-1:0] lane_ready, lane_pkt;

    logic strobe;
    assign strobe = !cs_n && !wr_n;

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_lane
        logic          hit, wr_ok, word_ok;
        logic [CW-1:0] fill;

        assign hit = (wr_sel == SW'(g));

        pfs_lane_ctrl #(.DEPTH(DEPTH), .LQ_DEPTH(LQ_DEPTH)) u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_hit      (strobe && hit),
            .end_hit     (!pkt_end_n && hit),
            .word_req    (word_pop && (rd_sel == SW'(g))),
            .pkt_req     (pkt_pop && (rd_sel == SW'(g))),
            .auto_en     (auto_en),
            .auto_len    (auto_len),
            .store_fill  (fill),
            .wr_ok       (wr_ok),
            .word_ok     (word_ok),
            .full        (fifo_full[g]),
            .words_ready (lane_ready[g]),
            .pkt_avail   (lane_pkt[g]),
            .pkt_len     (lane_len[g]),
            .err         (zero_pkt_err[g])
        );

        pfs_lane_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (wr_ok),
            .push_data (wr_data),
            .pop       (word_ok),
            .head_data (lane_head[g]),
            .fill      (fill)
        );

        assign fifo_empty[g] = (fill == '0);
    end

    assign rd_data   = lane_head[rd_sel];
    assign rd_valid  = lane_ready[rd_sel];
    assign pkt_avail = lane_pkt[rd_sel];
    assign pkt_len   = lane_len[rd_sel];

endmodule

// File: rtl/pkt_slave_fifo_chk.sv
module pkt_slave_fifo_chk #(
    parameter int NUM_FIFO = 4,
    parameter int SW       = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                wr_n,
    input logic [SW-1:0]       wr_sel,
    input logic [NUM_FIFO-1:0] fifo_full,
    input logic [NUM_FIFO-1:0] fifo_empty,
    input logic [SW-1:0]       rd_sel,
    input logic                word_pop,
    input logic                pkt_pop,
    input logic                rd_valid,
    input logic [NUM_FIFO-1:0] zero_pkt_err
);
    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_chk
        // R1
        no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((cs_n || wr_n) && !(word_pop && rd_sel == SW'(g))) |=> $stable(fifo_empty[g]));

        // R3
        empty_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !wr_n && wr_sel == SW'(g) && fifo_empty[g] && !fifo_full[g]) |=> !fifo_empty[g]);

        // R7
        err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            zero_pkt_err[g] |=> zero_pkt_err[g]);

        // R8
        full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fifo_full[g] && !((word_pop || pkt_pop) && rd_sel == SW'(g))) |=> fifo_full[g]);
    end

    // R9
    open_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty[rd_sel] |-> !rd_valid);

endmodule

bind pkt_slave_fifo pkt_slave_fifo_chk #(.NUM_FIFO(NUM_FIFO), .SW(SW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .wr_n         (wr_n),
    .wr_sel       (wr_sel),
    .fifo_full    (fifo_full),
    .fifo_empty   (fifo_empty),
    .rd_sel       (rd_sel),
    .word_pop     (word_pop),
    .pkt_pop      (pkt_pop),
    .rd_valid     (rd_valid),
    .zero_pkt_err (zero_pkt_err)
);

// File: tb/test_pkt_slave_fifo.sv
`timescale 1ns/1ps
module test_pkt_slave_fifo;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cs_n = 1, wr_n = 1, pkt_end_n = 1, auto_en = 0;
    logic [1:0]  wr_sel = 0, rd_sel = 0;
    logic [15:0] wr_data = 0;
    logic [4:0]  auto_len = 0;
    logic        word_pop = 0, pkt_pop = 0;
    logic [3:0]  fifo_full, fifo_empty, zero_pkt_err;
    logic [15:0] rd_data;
    logic        rd_valid, pkt_avail;
    logic [4:0]  pkt_len;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [15:0] mq [4][$];
    int          lq [4][$];
    int          opn [4], cw [4];
    bit          er [4];

    pkt_slave_fifo i_pkt_slave_fifo (.*);

    always #2.5 clk = ~clk;

    task automatic chk(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        for (int i = 0; i < 4; i++) begin
            bit fl, w, au, mn, rp, pp;
            int no;
            fl = (mq[i].size() == 16) || (lq[i].size() == 16);
            w  = !cs_n && !wr_n && wr_sel == i && !fl;
            no = opn[i] + (w ? 1 : 0);
            au = auto_en && w && auto_len != 0 && no >= auto_len;
            mn = !pkt_end_n && wr_sel == i && lq[i].size() < 16;
            rp = word_pop && rd_sel == i && cw[i] > 0;
            pp = pkt_pop && rd_sel == i && lq[i].size() > 0;
            if (rp) begin void'(mq[i].pop_front()); cw[i]--; end
            if (w)  mq[i].push_back(wr_data);
            if (pp) void'(lq[i].pop_front());
            if (au || mn) begin
                lq[i].push_back(no);
                cw[i] += no;
                if (mn && !au && no == 0) er[i] = 1;
                opn[i] = 0;
            end else opn[i] = no;
        end
    endtask

    task automatic compare();
        int s;
        for (int i = 0; i < 4; i++) begin
            chk("R3 empty", fifo_empty[i] == (mq[i].size() == 0), fifo_empty[i], mq[i].size() == 0);
            chk("R8 full", fifo_full[i] == (mq[i].size() == 16 || lq[i].size() == 16),
                fifo_full[i], mq[i].size() == 16 || lq[i].size() == 16);
            chk("R7 err", zero_pkt_err[i] == er[i], zero_pkt_err[i], er[i]);
        end
        s = rd_sel;
        chk("R9 rd_valid", rd_valid == (cw[s] > 0), rd_valid, cw[s] > 0);
        if (cw[s] > 0) chk("R2 rd_data", rd_data == mq[s][0], rd_data, mq[s][0]);
        chk("R10 pkt_avail", pkt_avail == (lq[s].size() > 0), pkt_avail, lq[s].size() > 0);
        if (lq[s].size() > 0) chk("R10 pkt_len", pkt_len == lq[s][0], pkt_len, lq[s][0]);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        #2;
        compare();
    endtask

    task automatic drv(bit cs, bit wr, int sel, int d, bit pe);
        cs_n = cs; wr_n = wr; wr_sel = 2'(sel); wr_data = 16'(d); pkt_end_n = pe;
        cyc();
        cs_n = 1; wr_n = 1; pkt_end_n = 1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R12 reset state
        chk("R12 empty", fifo_empty == 4'hF, fifo_empty, 4'hF);
        chk("R12 full", fifo_full == 4'h0, fifo_full, 0);
        chk("R12 err", zero_pkt_err == 4'h0, zero_pkt_err, 0);
        chk("R12 pkt", pkt_avail == 0 && rd_valid == 0, pkt_avail, 0);

        // R1: either strobe high stores nothing
        drv(1, 0, 0, 16'hDEAD, 1);
        drv(0, 1, 0, 16'hBEEF, 1);
        chk("R1 no write", fifo_empty[0] == 1, fifo_empty[0], 1);

        // R5: single write, packet-end two cycles later
        drv(0, 0, 0, 16'h1111, 1);
        idle(2);
        chk("R9 open hidden", rd_valid == 0, rd_valid, 0);
        drv(1, 1, 0, 0, 0);
        chk("R5 len", pkt_avail == 1 && pkt_len == 1, pkt_len, 1);

        // R4: burst of three, packet-end with last word
        drv(0, 0, 0, 16'hA1, 1);
        drv(0, 0, 0, 16'hA2, 1);
        drv(0, 0, 0, 16'hA3, 0);

        // R9: open words on lane 3 stay hidden
        rd_sel = 3;
        drv(0, 0, 3, 16'h3001, 1);
        drv(0, 0, 3, 16'h3002, 1);
        chk("R9 hidden", rd_valid == 0, rd_valid, 0);
        chk("R3 lane3 not empty", fifo_empty[3] == 0, fifo_empty[3], 0);
        drv(1, 1, 3, 0, 0);
        chk("R9 visible", rd_valid == 1 && rd_data == 16'h3001, rd_data, 16'h3001);

        // R10/R2: read lane 0
        rd_sel = 0;
        #0;
        chk("R2 head", rd_data == 16'h1111, rd_data, 16'h1111);
        pkt_pop = 1; cyc(); pkt_pop = 0;
        chk("R4 len", pkt_len == 3, pkt_len, 3);
        word_pop = 1; idle(4); word_pop = 0;
        chk("R10 drained", rd_valid == 0 && fifo_empty[0] == 1, rd_valid, 0);

        // R6/R7: auto-commit at 4 on lane 1, then an empty packet-end
        rd_sel = 1; auto_en = 1; auto_len = 4;
        for (int k = 0; k < 3; k++) drv(0, 0, 1, 16'h100 + k, 1);
        chk("R6 not yet", pkt_avail == 0, pkt_avail, 0);
        drv(0, 0, 1, 16'h103, 1);
        chk("R6 auto", pkt_avail == 1 && pkt_len == 4, pkt_len, 4);
        drv(1, 1, 1, 0, 0);
        chk("R7 err set", zero_pkt_err[1] == 1, zero_pkt_err[1], 1);
        drv(0, 0, 1, 16'h1FF, 0);
        pkt_pop = 1; cyc(); pkt_pop = 0;
        chk("R7 zero len", pkt_len == 0, pkt_len, 0);
        pkt_pop = 1; cyc(); pkt_pop = 0;
        chk("R4 auto mode one word", pkt_len == 1, pkt_len, 1);
        idle(3);
        chk("R7 sticky", zero_pkt_err[1] == 1, zero_pkt_err[1], 1);
        auto_en = 0;

        // R8/R11: overfill lane 2
        rd_sel = 2;
        for (int k = 0; k < 20; k++) drv(0, 0, 2, 16'h2000 + k, 1);
        chk("R8 full", fifo_full[2] == 1, fifo_full[2], 1);
        chk("R11 lane0 kept", fifo_empty[0] == 1 && zero_pkt_err[2] == 0, fifo_empty[0], 1);
        drv(1, 1, 2, 0, 0);
        chk("R8 len", pkt_len == 16, pkt_len, 16);
        word_pop = 1; idle(16); word_pop = 0;
        chk("R8 dropped", fifo_empty[2] == 1, fifo_empty[2], 1);
        pkt_pop = 1; cyc(); pkt_pop = 0;

        // Random phase compared every cycle
        for (int k = 0; k < 3000; k++) begin
            cs_n = 1'($urandom_range(0, 3) == 0);
            wr_n = 1'($urandom_range(0, 3) == 0);
            wr_sel = 2'($urandom_range(0, 3));
            wr_data = 16'($urandom);
            pkt_end_n = !($urandom_range(0, 9) == 0);
            auto_en = 1'($urandom_range(0, 1));
            auto_len = 5'($urandom_range(0, 8));
            rd_sel = 2'($urandom_range(0, 3));
            word_pop = 1'($urandom_range(0, 1));
            pkt_pop = 1'($urandom_range(0, 2) == 0);
            cyc();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule